// File: doc/BRIEF.md
# Serial Command Word Receiver

This block is the serial front end of a two-channel converter control port. A host drives a serial clock, a data line and an active-low select/load line. While select is low, each rising edge of the serial clock shifts one data bit, most significant bit first, into a 32-bit shift register. The top bit of that register is driven on a serial output. Several receivers can therefore be chained: each output feeds the next data input, and all of them share the clock and select lines.

When select returns high, the frame ends. The block then copies the low 24 bits of the shift register into a held command word and raises a one-cycle load strobe. A host may send either a 24-bit frame or a 32-bit frame, because only the last 24 bits shifted in are ever decoded. The three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser, and clock edges are found in the system clock domain. The serial clock must run slower than one quarter of the system clock.

The frame controller is a four-state machine:
- `ST_IDLE`: select is high.
- `ST_ARMED`: select is low, but a low serial clock has not yet been seen.
- `ST_SHIFT`: shifting is enabled.
- `ST_LOAD`: the strobe cycle.

Its transitions are:
- IDLE→ARMED when select falls.
- ARMED→SHIFT when the synchronised serial clock is low.
- ARMED→LOAD and SHIFT→LOAD when select rises.
- LOAD→ARMED when select is already low again.
- LOAD→IDLE otherwise.

Top module: `serial_cmd_rx`

## Requirements
- R1: While selected, each rising serial clock edge shifts the data bit into bit 0 and moves every other bit up by one, so the first bit sent ends highest. After a 24-bit frame, `cmd_word` equals the frame with its first bit in `cmd_word[23]`.
- R2: Serial clock edges while `cs_ld_n` is high leave the shift register unchanged, and so also leave `sdo` and the next decoded word unchanged.
- R3: In a 32-bit frame the first 8 bits have no effect on `cmd_word`, which equals the last 24 bits sent.
- R4: `cmd_load` is high for exactly one system clock cycle per frame end. `cmd_word` already holds the new word in that cycle and keeps it until the next frame end.
- R5: `sdo` always equals shift register bit 31. It is updated after each shift, so a bit reappears on `sdo` 32 shifts after it entered, and this carries across frames.
- R6: Power-up reset (`rst_n` low) and clear (`clr_n` low) both asynchronously zero the shift register and `cmd_word`, and both return the controller to idle.
- R7: If the serial clock is already high when `cs_ld_n` falls, that level is not taken as an edge. Only a rising edge that follows a low level seen while selected shifts a bit.
- R8: A frame shorter than 24 bits is decoded with no length check. `cmd_word` is register bits 23..0, with the older bits moved up by the number of bits sent.
- R9: `cmd_load` never pulses except after a rise of `cs_ld_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| clr_n | input | 1 | Asynchronous clear, active low |
| sck | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| cs_ld_n | input | 1 | Select/load, active low, asynchronous |
| sdo | output | 1 | Serial data out (shift register top bit) |
| cmd_word | output | 24 | Held command word from the last frame |
| cmd_load | output | 1 | One-cycle strobe at frame end |

## Verification
Frames are sent in four lengths:
- 24-bit frames check bit order.
- 32-bit frames show that the leading byte is dropped.
- 8-bit frames expose the old register contents moving up.
- Frames with varied patterns vary the data.

Serial clock toggles while deselected are followed by a short frame, so any stray shift would show in the decoded word. A frame that begins with the serial clock high tells a genuine edge apart from a level already present at select fall. After every serial clock fall, `sdo` is compared with a bench model, which shows the 32-bit chaining delay across frame boundaries.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_LOAD  = 2'd3
    } scr_state_e;

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= RST_VAL;
        end else begin
            stage_q[0] <= d_async;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else begin
                    stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/scr_fsm.sv
module scr_fsm
    import scr_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       cs_s,
    input  logic       sck_s,
    output logic       shift_en,
    output logic       cap_en,
    output logic       load_pulse,
    output scr_state_e state
);

    scr_state_e state_nx;
    logic       sck_d;
    logic       sck_rise;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= ST_IDLE;
            sck_d <= 1'b0;
        end else begin
            state <= state_nx;
            sck_d <= sck_s;
        end
    end

    assign sck_rise = sck_s && !sck_d;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!cs_s) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (cs_s)        state_nx = ST_LOAD;
                else if (!sck_s) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_s) state_nx = ST_LOAD;
            end
            ST_LOAD: begin
                if (!cs_s) state_nx = ST_ARMED;
                else       state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_en   = 1'b0;
        cap_en     = 1'b0;
        load_pulse = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ARMED: cap_en = cs_s;
            ST_SHIFT: begin
                shift_en = !cs_s && sck_rise;
                cap_en   = cs_s;
            end
            ST_LOAD:  load_pulse = 1'b1;
            default:  ;
        endcase
    end

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!arst_n)
        load_pulse |=> !load_pulse);

    p_load_after_rise_r9: assert property (@(posedge clk) disable iff (!arst_n)
        load_pulse |-> $past(cs_s));

    p_no_level_edge_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_ARMED) && sck_s |=> !shift_en);

endmodule

// File: rtl/scr_shift.sv
module scr_shift #(
    parameter int SR_W = 32
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            shift_en,
    input  logic            sdi_s,
    output logic [SR_W-1:0] sr,
    output logic            sdo
);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sr <= '0;
        end else if (shift_en) begin
            sr <= {sr[SR_W-2:0], sdi_s};
        end
    end

    assign sdo = sr[SR_W-1];

    p_shift_msb_r1: assert property (@(posedge clk) disable iff (!arst_n)
        shift_en |=> (sr[0] == $past(sdi_s)) && (sr[SR_W-1:1] == $past(sr[SR_W-2:0])));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!arst_n)
        !shift_en |=> $stable(sr));

    p_sdo_top_r5: assert property (@(posedge clk) disable iff (!arst_n)
        shift_en |=> sdo == $past(sr[SR_W-2]));

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx #(
    parameter int SR_W        = 32,
    parameter int CMD_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             sck,
    input  logic             sdi,
    input  logic             cs_ld_n,
    output logic             sdo,
    output logic [CMD_W-1:0] cmd_word,
    output logic             cmd_load
);
    import scr_pkg::*;

    localparam int            NSYNC    = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b100;

    logic             arst_n;
    logic [NSYNC-1:0] pins_s;
    logic             cs_s;
    logic             sck_s;
    logic             sdi_s;
    logic             shift_en;
    logic             cap_en;
    logic [SR_W-1:0]  sr;
    scr_state_e       state;

    assign arst_n = rst_n & clr_n;

    scr_sync #(
        .WIDTH   (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cs_ld_n, sck, sdi}),
        .q_sync  (pins_s)
    );

    assign cs_s  = pins_s[2];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[0];

    scr_fsm u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .cs_s       (cs_s),
        .sck_s      (sck_s),
        .shift_en   (shift_en),
        .cap_en     (cap_en),
        .load_pulse (cmd_load),
        .state      (state)
    );

    scr_shift #(
        .SR_W (SR_W)
    ) u_shift (
        .clk      (clk),
        .arst_n   (arst_n),
        .shift_en (shift_en),
        .sdi_s    (sdi_s),
        .sr       (sr),
        .sdo      (sdo)
    );

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cmd_word <= '0;
        end else if (cap_en) begin
            cmd_word <= sr[CMD_W-1:0];
        end
    end

    p_word_hold_r4: assert property (@(posedge clk) disable iff (!arst_n)
        cmd_load |=> $stable(cmd_word));

    p_word_is_low_bits_r3: assert property (@(posedge clk) disable iff (!arst_n)
        cmd_load |-> cmd_word == sr[CMD_W-1:0]);

    p_no_shift_deselected_r2: assert property (@(posedge clk) disable iff (!arst_n)
        cs_s |-> !shift_en);

endmodule

// File: tb/tb_serial_cmd_rx.sv
module tb_serial_cmd_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        cs_ld_n = 1'b1;
    logic        sdo;
    logic [23:0] cmd_word;
    logic        cmd_load;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] model = '0;
    logic [23:0] exp_q [$];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    serial_cmd_rx dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .sck      (sck),
        .sdi      (sdi),
        .cs_ld_n  (cs_ld_n),
        .sdo      (sdo),
        .cmd_word (cmd_word),
        .cmd_load (cmd_load)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] bits, input int n, input bit sck_hi_start);
        if (sck_hi_start) begin
            sck = 1'b1;
            wait_clk(5);
        end
        cs_ld_n = 1'b0;
        wait_clk(5);
        sck = 1'b0;
        wait_clk(5);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            wait_clk(5);
            sck = 1'b1;
            model = {model[30:0], bits[i]};
            wait_clk(5);
            sck = 1'b0;
            check(sdo == model[31], "R5 sdo", {31'd0, sdo}, {31'd0, model[31]});
        end
        wait_clk(5);
        exp_q.push_back(model[23:0]);
        cs_ld_n = 1'b1;
        wait_clk(12);
        check(exp_q.size() == 0, "R4 strobe seen", exp_q.size(), 0);
    endtask

    // Scoreboard monitor: pops the expected word at each strobe
    logic        prev_load = 1'b0;
    logic        hold_chk = 1'b0;
    logic [23:0] hold_val = '0;
    always @(negedge clk) begin
        if (rst_n && clr_n) begin
            if (hold_chk) begin
                check(cmd_word == hold_val, "R4 word held", {8'd0, cmd_word}, {8'd0, hold_val});
                hold_chk = 1'b0;
            end
            if (cmd_load) begin
                if (prev_load)
                    check(1'b0, "R4 strobe width", 32'd2, 32'd1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected strobe", 32'd1, 32'd0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check(cmd_word == e, "R1/R3/R8 word", {8'd0, cmd_word}, {8'd0, e});
                    hold_chk = 1'b1;
                    hold_val = e;
                end
            end
        end
        prev_load = cmd_load;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            check(1'b0, "watchdog", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        wait_clk(5);
        // R6: reset state
        check(cmd_word == 24'd0, "R6 reset word", {8'd0, cmd_word}, 32'd0);
        check(sdo == 1'b0, "R6 reset sdo", {31'd0, sdo}, 32'd0);
        check(cmd_load == 1'b0, "R9 reset strobe", {31'd0, cmd_load}, 32'd0);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: 24-bit frame, first bit lands in the top of the word
        send_frame(32'h00A5C33C, 24, 1'b0);
        // R3: 32-bit frame, leading byte dropped
        send_frame(32'hFF123456, 32, 1'b0);
        check(sdo == 1'b1, "R5 sdo after 32 bits", {31'd0, sdo}, 32'd1);
        // R7: serial clock high when select falls
        send_frame(32'h000F0F0F, 24, 1'b1);

        // R2: clock toggles while deselected are ignored
        for (int k = 0; k < 6; k++) begin
            sdi = k[0];
            wait_clk(5);
            sck = 1'b1;
            wait_clk(5);
            sck = 1'b0;
        end
        wait_clk(5);
        check(sdo == model[31], "R2 sdo unchanged", {31'd0, sdo}, {31'd0, model[31]});
        check(cmd_load == 1'b0, "R9 no strobe deselected", {31'd0, cmd_load}, 32'd0);
        // R8: short frame decodes older bits moved up
        send_frame(32'h0000005A, 8, 1'b0);

        // R5: daisy chain carries previous frame out on sdo
        send_frame(32'hDEADBEEF, 32, 1'b0);
        send_frame(32'h00000000, 8, 1'b0);

        // R6: clear zeroes everything
        clr_n = 1'b0;
        wait_clk(3);
        model = '0;
        check(sdo == 1'b0, "R6 clear sdo", {31'd0, sdo}, 32'd0);
        check(cmd_word == 24'd0, "R6 clear word", {8'd0, cmd_word}, 32'd0);
        clr_n = 1'b1;
        wait_clk(3);
        send_frame(32'h000000C3, 8, 1'b0);

        // Varied patterns, mixed frame lengths
        lfsr = 32'h1D872B41;
        for (int f = 0; f < 6; f++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]} ^ (lfsr << 7);
            send_frame(lfsr, (f % 2 == 0) ? 32 : 24, f == 3);
        end

        wait_clk(10);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule